// File: doc/BRIEF.md
# Round-Robin DMA Channel Arbiter

This block is the only host-bus master for a set of channel DMA engines. Each channel raises a request and presents its address, write flag and write data. When the arbiter is idle it picks one requesting channel by rotating priority and registers a one-hot grant. It then drives that channel's transfer onto the host-bus master port and holds it there until the bus signals ready. On the ready cycle, read data goes only to the granted channel's return lane. A done pulse reaches that channel alone. The channel just served then drops to the lowest priority.

The block also gathers per-channel interrupt events into a sticky pending vector. Software clears a pending bit by writing 1 to it. A per-channel enable mask gates the pending bits, and the gated bits are ORed into a single interrupt line.

Top module: `dma_rr_arbiter`

## Requirements
- R1: At most one bit of `ch_gnt` is set at any time, and a grant is only given to a channel whose request is asserted.
- R2: While no request is pending and no grant is held, `ch_gnt` stays zero and the priority pointer does not move. The first grant after an idle stretch follows the same order it would have without the stretch.
- R3: A grant, and the host-bus address, write flag and write data, stay unchanged on every cycle where `hb_ready` is low.
- R4: The rotation starts at channel 0 after reset. After a transfer, the search starts at the channel one index above the channel just served and wraps from channel 7 to channel 0, so the served channel has the lowest priority.
- R5: `hb_req` is high exactly while a grant is held. `hb_addr`, `hb_we` and `hb_wdata` carry the granted channel's lane. Lane i of `ch_addr` is `ch_addr[i*AW +: AW]`, and the same slicing applies to `ch_wdata`. All three are zero when there is no grant.
- R6: When `hb_ready` is high with a grant held, `ch_done` is one-hot on the granted channel. The granted lane of `ch_rdata` (lane i is `ch_rdata[i*DW +: DW]`) equals `hb_rdata`, and every other lane is zero.
- R7: A high `irq_evt[i]` sets `irq_pend[i]` on the next edge. A high `irq_clr[i]` clears it. When both are high in the same cycle, the set wins.
- R8: `irq` is high exactly when some bit is set in both `irq_pend` and `irq_en`.
- R9: While `rst_n` is low, `ch_gnt`, `hb_req`, `ch_done`, `irq_pend` and `irq` are all zero.
- R10: From idle, a grant appears on the first clock edge that sees a request. The edge that sees `hb_ready` high with a grant held clears the grant, which leaves one cycle with no grant before the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NCH | Per-channel transfer request |
| ch_we | input | NCH | Per-channel write flag (1 = write) |
| ch_addr | input | NCH*AW | Per-channel address lanes |
| ch_wdata | input | NCH*DW | Per-channel write data lanes |
| ch_gnt | output | NCH | One-hot grant |
| ch_done | output | NCH | Transfer completion pulse to the granted channel |
| ch_rdata | output | NCH*DW | Per-channel read data lanes (only the granted lane is nonzero) |
| hb_req | output | 1 | Host-bus transfer valid |
| hb_we | output | 1 | Host-bus write flag |
| hb_addr | output | AW | Host-bus address |
| hb_wdata | output | DW | Host-bus write data |
| hb_rdata | input | DW | Host-bus read data |
| hb_ready | input | 1 | Host-bus transfer complete |
| irq_evt | input | NCH | Per-channel interrupt event pulse |
| irq_clr | input | NCH | Write-1-to-clear strobe for the pending bits |
| irq_en | input | NCH | Per-channel interrupt enable |
| irq_pend | output | NCH | Sticky pending bits |
| irq | output | 1 | Consolidated interrupt |

## Verification
The assertions assume that a channel keeps its request, address, write flag and write data steady from the moment it requests until it sees its done pulse. They also assume that `hb_ready` is only raised while a grant is held. The stimulus follows both rules. It drops a channel's request on the cycle after that channel's done pulse, and it raises `hb_ready` only after it has seen a grant. The hold check relies on the bus keeping ready low for several cycles, and the stimulus does that before completing the transfer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_st_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  ptr,
  output logic [IW-1:0]  win,
  output logic           vld
);
  int s;

  // Scan upward from the pointer with wrap; the first requester found wins.
  always_comb begin
    win = '0;
    vld = 1'b0;
    s   = 0;
    for (int k = 0; k < NCH; k++) begin
      s = int'(ptr) + k;
      if (s >= NCH) s = s - NCH;
      if (!vld && req[s]) begin
        vld = 1'b1;
        win = s[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/bus_route.sv
module bus_route #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [NCH-1:0]    gnt,
  input  logic [IW-1:0]     sel,
  input  logic [NCH-1:0]    ch_we,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH*DW-1:0] ch_wdata,
  input  logic [DW-1:0]     hb_rdata,
  input  logic              hb_ready,
  output logic              hb_req,
  output logic              hb_we,
  output logic [AW-1:0]     hb_addr,
  output logic [DW-1:0]     hb_wdata,
  output logic [NCH-1:0]    ch_done,
  output logic [NCH*DW-1:0] ch_rdata
);
  // Outbound: the registered index selects one lane.
  always_comb begin
    hb_req   = busy;
    hb_we    = busy ? ch_we[sel] : 1'b0;
    hb_addr  = busy ? ch_addr[sel*AW +: AW] : '0;
    hb_wdata = busy ? ch_wdata[sel*DW +: DW] : '0;
  end

  // Return path: read data and done reach the granted lane only.
  for (genvar i = 0; i < NCH; i++) begin : g_ret
    assign ch_rdata[i*DW +: DW] = gnt[i] ? hb_rdata : '0;
    assign ch_done[i]           = gnt[i] & hb_ready;
  end

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done != '0) |-> (hb_req && $onehot(ch_done)));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_req && !hb_ready) |=> (hb_req && $stable(hb_addr) && $stable(hb_we)
                               && $stable(hb_wdata)));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_evt,
  input  logic [NCH-1:0] irq_clr,
  input  logic [NCH-1:0] irq_en,
  output logic [NCH-1:0] irq_pend,
  output logic           irq
);
  logic [NCH-1:0] pend_q, pend_d;
  logic           upd;

  always_comb begin
    upd    = |(irq_evt | irq_clr);
    pend_d = (pend_q & ~irq_clr) | irq_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign irq_pend = pend_q;
  assign irq      = |(pend_q & irq_en);

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != '0) |=> ((pend_q & $past(irq_evt)) == $past(irq_evt)));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_clr & ~irq_evt) != '0) |=> ((pend_q & $past(irq_clr & ~irq_evt)) == '0));
endmodule

// File: rtl/dma_rr_arbiter.sv
module dma_rr_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_req,
  input  logic [NCH-1:0]    ch_we,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH*DW-1:0] ch_wdata,
  output logic [NCH-1:0]    ch_gnt,
  output logic [NCH-1:0]    ch_done,
  output logic [NCH*DW-1:0] ch_rdata,
  output logic              hb_req,
  output logic              hb_we,
  output logic [AW-1:0]     hb_addr,
  output logic [DW-1:0]     hb_wdata,
  input  logic [DW-1:0]     hb_rdata,
  input  logic              hb_ready,
  input  logic [NCH-1:0]    irq_evt,
  input  logic [NCH-1:0]    irq_clr,
  input  logic [NCH-1:0]    irq_en,
  output logic [NCH-1:0]    irq_pend,
  output logic              irq
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  arb_st_e        st_q, st_d;
  logic [IW-1:0]  ptr_q, ptr_d, cur_q, cur_d, win_idx;
  logic [NCH-1:0] gnt_q, gnt_d;
  logic           win_vld, busy;

  rr_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req(ch_req), .ptr(ptr_q), .win(win_idx), .vld(win_vld)
  );

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    cur_d = cur_q;
    gnt_d = gnt_q;
    case (st_q)
      ARB_IDLE: if (win_vld) begin
        st_d  = ARB_BUSY;
        cur_d = win_idx;
        gnt_d = NCH'(1) << win_idx;
      end
      ARB_BUSY: if (hb_ready) begin
        st_d  = ARB_IDLE;
        gnt_d = '0;
        ptr_d = (cur_q == IW'(NCH-1)) ? '0 : cur_q + 1'b1;
      end
      default: st_d = ARB_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ARB_IDLE;
      ptr_q <= '0;
      cur_q <= '0;
      gnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      cur_q <= cur_d;
      gnt_q <= gnt_d;
    end
  end

  assign busy   = (st_q == ARB_BUSY);
  assign ch_gnt = gnt_q;

  bus_route #(.NCH(NCH), .AW(AW), .DW(DW), .IW(IW)) u_route (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gnt(gnt_q), .sel(cur_q),
    .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .hb_rdata(hb_rdata), .hb_ready(hb_ready),
    .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .ch_done(ch_done), .ch_rdata(ch_rdata)
  );

  irq_merge #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .irq_clr(irq_clr),
    .irq_en(irq_en), .irq_pend(irq_pend), .irq(irq)
  );

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_gnt));
  p_gnt_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0) |-> ((ch_gnt & ch_req) != '0));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req == '0 && ch_gnt == '0) |=> (ch_gnt == '0 && $stable(ptr_q)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && !hb_ready) |=> $stable(ch_gnt));
  p_win_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ch_req[win_idx]);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && hb_ready) |=> (ch_gnt == '0));
  p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt == '0 && ch_req != '0) |=> (ch_gnt != '0));
endmodule

// File: tb/sim_dma_rr_arbiter.sv
module sim_dma_rr_arbiter;
  localparam int NCH = 8;
  localparam int AW  = 32;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    ch_req, ch_we, ch_gnt, ch_done;
  logic [NCH*AW-1:0] ch_addr;
  logic [NCH*DW-1:0] ch_wdata, ch_rdata;
  logic              hb_req, hb_we, hb_ready, irq;
  logic [AW-1:0]     hb_addr;
  logic [DW-1:0]     hb_wdata, hb_rdata;
  logic [NCH-1:0]    irq_evt, irq_clr, irq_en, irq_pend;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  always #5 clk = ~clk;

  dma_rr_arbiter #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_we(ch_we),
    .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_gnt(ch_gnt),
    .ch_done(ch_done), .ch_rdata(ch_rdata), .hb_req(hb_req),
    .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_rdata(hb_rdata), .hb_ready(hb_ready), .irq_evt(irq_evt),
    .irq_clr(irq_clr), .irq_en(irq_en), .irq_pend(irq_pend), .irq(irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Serve the next grant, expecting channel e; hold ready low for hold cycles.
  task automatic serve(input int e, input int hold);
    logic [NCH-1:0] g;
    logic [DW-1:0]  rd;
    bit             lanes_ok;
    for (int w = 0; w < 20 && ch_gnt == '0; w++) step();
    g = ch_gnt;
    chk(g == NCH'(1) << e, "R4", 64'(g), 64'(NCH'(1) << e));
    chk(hb_req && hb_addr == 32'h1000 + 32'(e * 16) && hb_we == e[0]
        && hb_wdata == 32'hD000_0000 + 32'(e), "R5", 64'(hb_addr),
        64'(32'h1000 + 32'(e * 16)));
    for (int h = 0; h < hold; h++) begin
      step();
      chk(ch_gnt == g && hb_addr == 32'h1000 + 32'(e * 16), "R3",
          64'(ch_gnt), 64'(g));
    end
    rd = 32'hA500_0000 + 32'(e);
    hb_rdata = rd;
    hb_ready = 1'b1;
    #1;
    chk(ch_done == NCH'(1) << e, "R6", 64'(ch_done), 64'(NCH'(1) << e));
    lanes_ok = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (ch_rdata[i*DW +: DW] != ((i == e) ? rd : '0)) lanes_ok = 1'b0;
    chk(lanes_ok, "R6", 64'(ch_rdata[e*DW +: DW]), 64'(rd));
    step();
    hb_ready = 1'b0;
    hb_rdata = '0;
    ch_req[e] = 1'b0;
    chk(ch_gnt == '0 && !hb_req, "R10", 64'(ch_gnt), 64'h0);
  endtask

  task automatic t_reset();
    chk(ch_gnt == '0 && !hb_req && ch_done == '0, "R9", 64'(ch_gnt), 64'h0);
    chk(irq_pend == '0 && !irq, "R9", 64'(irq_pend), 64'h0);
  endtask

  task automatic t_single();
    ch_req[3] = 1'b1;
    step();
    chk(ch_gnt == 8'h08, "R10", 64'(ch_gnt), 64'h08);
    serve(3, 3);
  endtask

  task automatic t_rotation();
    ch_req = '1;
    for (int k = 0; k < NCH; k++) serve((4 + k) % NCH, k % 2);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 5; k++) begin
      step();
      chk(ch_gnt == '0 && !hb_req, "R2", 64'(ch_gnt), 64'h0);
    end
    ch_req = 8'h22;
    serve(5, 0);
    serve(1, 1);
  endtask

  task automatic t_wrap();
    ch_req = 8'h86;
    serve(2, 0);
    serve(7, 2);
    serve(1, 0);
  endtask

  task automatic t_irq();
    irq_en  = 8'h0F;
    irq_evt = 8'h21;
    step();
    irq_evt = '0;
    chk(irq_pend == 8'h21, "R7", 64'(irq_pend), 64'h21);
    chk(irq == 1'b1, "R8", 64'(irq), 64'h1);
    irq_clr = 8'h01;
    step();
    irq_clr = '0;
    chk(irq_pend == 8'h20, "R7", 64'(irq_pend), 64'h20);
    chk(irq == 1'b0, "R8", 64'(irq), 64'h0);
    irq_en = 8'hFF;
    #1;
    chk(irq == 1'b1, "R8", 64'(irq), 64'h1);
    irq_evt = 8'h20;
    irq_clr = 8'h20;
    step();
    irq_evt = '0;
    irq_clr = '0;
    chk(irq_pend == 8'h20, "R7", 64'(irq_pend), 64'h20);
    irq_clr = 8'h20;
    step();
    irq_clr = '0;
    chk(irq_pend == '0 && !irq, "R7", 64'(irq_pend), 64'h0);
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    ch_req   = '0;
    hb_ready = 1'b0;
    hb_rdata = '0;
    irq_evt  = '0;
    irq_clr  = '0;
    irq_en   = '0;
    for (int i = 0; i < NCH; i++) begin
      ch_addr[i*AW +: AW]  = 32'h1000 + 32'(i * 16);
      ch_wdata[i*DW +: DW] = 32'hD000_0000 + 32'(i);
      ch_we[i]             = i[0];
    end
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_single();
    t_rotation();
    t_idle();
    t_wrap();
    t_irq();
    finish_run();
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule